// File: doc/BRIEF.md
# Offset-Cancelling Measurement Sequencer

This block runs one measurement cycle per accepted start request and returns four offset-free readings: the voltage of each of two series cells, the pack current, and the thermistor drop. An amplifier or ADC offset is removed by taking two conversions per channel. The first conversion is a baseline: the amplifier inputs are shorted, or the high reference is applied for the thermistor. The second conversion is the real signal. The block keeps the difference of the two conversions.

The block drives an analog select code and a reference-select line. It talks to an external 12-bit signed ADC through a start pulse and a done pulse. After each select change it waits a programmable number of settling cycles before it starts a conversion. The current channel has one more correction. The sense-resistor bias can be captured once, in a cycle requested at the start of charging, and it is then subtracted from every later current reading. Results saturate to 13 signed bits.

Top module: `offset_meas_seq`

## Requirements
- R1: A cycle makes eight conversions in this fixed order of (mux_sel, ref_hi): (0,0),(1,0),(0,0),(2,0),(0,0),(3,0),(4,1),(4,0). The select codes are 0 = shorted inputs, 1 = cell 1, 2 = cell 2, 3 = sense resistor, 4 = thermistor. ref_hi = 1 applies the high reference and 0 applies analog ground. ref_hi is 1 only while mux_sel is 4.
- R2: cell1_out and cell2_out each receive the signal code minus the shorted baseline code, taken as 13-bit signed values.
- R3: temp_out receives the code taken with the high reference minus the code taken with analog ground.
- R4: A start accepted with bias_cap = 1 stores that cycle's current difference (sense code minus baseline) as the bias, and cur_out becomes 0 in that cycle.
- R5: In every other cycle, cur_out is the current difference minus the stored bias, saturated to the range -4096..4095.
- R6: adc_start is a one-cycle pulse. It is raised only when mux_sel and ref_hi have been unchanged for at least SETTLE_CYC cycles. A new adc_start follows only after adc_done.
- R7: Each output register changes only on the adc_done of its channel's second conversion. Otherwise it holds its value, including through the first half of a new cycle.
- R8: cycle_done pulses for one cycle on the clock edge at which temp_out takes its new value, after the eighth conversion.
- R9: start is ignored while a cycle is running, and bias_cap is used only together with an accepted start.
- R10: After reset, all outputs are 0, the stored bias is 0, mux_sel is 0 and ref_hi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a measurement cycle (used when idle) |
| bias_cap | input | 1 | With start: capture the sense bias in this cycle |
| adc_done | input | 1 | Conversion finished, adc_code valid |
| adc_code | input | 12 | Signed conversion result |
| adc_start | output | 1 | Start a conversion |
| mux_sel | output | 3 | Analog select code |
| ref_hi | output | 1 | 1 = high reference, 0 = analog ground |
| cell1_out | output | 13 | Offset-free cell 1 code |
| cell2_out | output | 13 | Offset-free cell 2 code |
| cur_out | output | 13 | Offset-free, bias-corrected current code |
| temp_out | output | 13 | Thermistor difference code |
| cycle_done | output | 1 | All four outputs updated |

## Verification
The two operations that can fall on one edge are the bias capture and the current result write. In a capture cycle, the same adc_done stores the new bias and writes cur_out as zero. In the next cycle, that bias must already be subtracted. The bench provokes this by sweeping baseline and signal codes across the whole signed range. It requests captures whose bias sits at both extremes, so the following cycles must saturate to +4095 and -4096. A start with bias_cap raised in the middle of a cycle must leave both the bias and the conversion count untouched. Every current value is compared with a result the bench computes from the codes its ADC model returned.

// File: rtl/offset_meas_seq.sv
module offset_meas_seq #(
  parameter int ADC_W      = 12,
  parameter int SETTLE_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    bias_cap,
  input  logic                    adc_done,
  input  logic signed [ADC_W-1:0] adc_code,
  output logic                    adc_start,
  output logic [2:0]              mux_sel,
  output logic                    ref_hi,
  output logic signed [ADC_W:0]   cell1_out,
  output logic signed [ADC_W:0]   cell2_out,
  output logic signed [ADC_W:0]   cur_out,
  output logic signed [ADC_W:0]   temp_out,
  output logic                    cycle_done
);
  localparam int OW = ADC_W + 1;
  localparam int CW = $clog2(SETTLE_CYC + 2);
  localparam logic signed [OW-1:0] MAXV = {1'b0, {ADC_W{1'b1}}};
  localparam logic signed [OW-1:0] MINV = {1'b1, {ADC_W{1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_GO, S_WAIT} st_t;
  st_t st;
  logic [2:0] step;
  logic [CW-1:0] cnt;
  logic take_bias;
  logic signed [ADC_W-1:0] base;
  logic signed [OW-1:0] bias;

  wire busy = (st != S_IDLE);
  wire [1:0] chan = step[2:1];
  wire ph = step[0];

  assign mux_sel = !busy ? 3'd0 : (chan == 2'd3) ? 3'd4 : ph ? ({1'b0, chan} + 3'd1) : 3'd0;
  assign ref_hi  = busy && chan == 2'd3 && !ph;
  assign adc_start = (st == S_GO);

  wire signed [OW-1:0] code_x = {adc_code[ADC_W-1], adc_code};
  wire signed [OW-1:0] base_x = {base[ADC_W-1], base};
  wire signed [OW-1:0] diff   = (chan == 2'd3) ? (base_x - code_x) : (code_x - base_x);
  wire signed [OW:0]   cur_full = {diff[OW-1], diff} - {bias[OW-1], bias};
  wire signed [OW-1:0] cur_sat  = (cur_full[OW] != cur_full[OW-1]) ?
                                  (cur_full[OW] ? MINV : MAXV) : cur_full[OW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      step <= '0;
      cnt <= '0;
      take_bias <= 1'b0;
      base <= '0;
      bias <= '0;
      cell1_out <= '0;
      cell2_out <= '0;
      cur_out <= '0;
      temp_out <= '0;
      cycle_done <= 1'b0;
    end else begin
      cycle_done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_SETTLE;
          step <= '0;
          cnt <= '0;
          take_bias <= bias_cap;
        end
        S_SETTLE: if (cnt == CW'(SETTLE_CYC)) st <= S_GO;
                  else cnt <= cnt + 1'b1;
        S_GO: st <= S_WAIT;
        S_WAIT: if (adc_done) begin
          if (!ph) base <= adc_code;
          else begin
            case (chan)
              2'd0: cell1_out <= diff;
              2'd1: cell2_out <= diff;
              2'd2: if (take_bias) begin
                      bias <= diff;
                      cur_out <= '0;
                    end else cur_out <= cur_sat;
              default: temp_out <= diff;
            endcase
          end
          cnt <= '0;
          if (step == 3'd7) begin
            st <= S_IDLE;
            cycle_done <= 1'b1;
          end else begin
            step <= step + 3'd1;
            st <= S_SETTLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [3:0] prev_sel;
  logic [CW-1:0] quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel <= '0;
      quiet <= '0;
    end else begin
      prev_sel <= {mux_sel, ref_hi};
      if ({mux_sel, ref_hi} != prev_sel) quiet <= '0;
      else if (quiet != CW'(SETTLE_CYC)) quiet <= quiet + 1'b1;
    end
  end

  assert_settled_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> quiet == CW'(SETTLE_CYC));
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  assert_ref_only_therm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hi |-> mux_sel == 3'd4);
  assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_done |=> $stable(cell1_out) && $stable(cell2_out) && $stable(cur_out) && $stable(temp_out));
  assert_done_after_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> $past(adc_done));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);
endmodule

// File: tb/test_offset_meas_seq.sv
module test_offset_meas_seq;
  localparam int SETTLE = 3;
  logic clk = 0, rst_n = 0, start = 0, bias_cap = 0, adc_done = 0;
  logic signed [11:0] adc_code = '0;
  logic adc_start, ref_hi, cycle_done;
  logic [2:0] mux_sel;
  logic signed [12:0] cell1_out, cell2_out, cur_out, temp_out;

  offset_meas_seq #(.ADC_W(12), .SETTLE_CYC(SETTLE)) i_offset_meas_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bias_cap(bias_cap),
    .adc_done(adc_done), .adc_code(adc_code), .adc_start(adc_start),
    .mux_sel(mux_sel), .ref_hi(ref_hi), .cell1_out(cell1_out),
    .cell2_out(cell2_out), .cur_out(cur_out), .temp_out(temp_out),
    .cycle_done(cycle_done));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int v_short, v_c1, v_c2, v_cur, v_thi, v_tlo;
  int conv_n = 0;
  int rec_mux[8], rec_ref[8];
  int bias_m = 0;
  int e_c1 = 0, e_c2 = 0, e_cur = 0, e_t = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat13(input int x);
    if (x > 4095) return 4095;
    if (x < -4096) return -4096;
    return x;
  endfunction

  function automatic int exp_mux(input int k);
    if (k / 2 == 3) return 4;
    return (k % 2) ? k / 2 + 1 : 0;
  endfunction

  function automatic int off_of(input int i);
    case (i)
      0: return -2048; 1: return -500; 2: return 0; 3: return 333; default: return 2047;
    endcase
  endfunction

  function automatic int sig_of(input int j);
    case (j)
      0: return -2048; 1: return -1; 2: return 0; 3: return 1; 4: return 1000; default: return 2047;
    endcase
  endfunction

  // ADC model
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        rec_mux[conv_n % 8] = int'(mux_sel);
        rec_ref[conv_n % 8] = int'(ref_hi);
        conv_n++;
        @(negedge clk);
        @(negedge clk);
        case (mux_sel)
          3'd0: adc_code = 12'(v_short);
          3'd1: adc_code = 12'(v_c1);
          3'd2: adc_code = 12'(v_c2);
          3'd3: adc_code = 12'(v_cur);
          default: adc_code = ref_hi ? 12'(v_thi) : 12'(v_tlo);
        endcase
        adc_done = 1;
        @(negedge clk);
        adc_done = 0;
      end
    end
  end

  // settle monitor (R6)
  initial begin
    int q = 0;
    logic [3:0] prev = '0;
    forever begin
      @(negedge clk);
      if ({mux_sel, ref_hi} != prev) q = 0; else q++;
      prev = {mux_sel, ref_hi};
      if (rst_n && adc_start) chk("R6 settle before start", (q >= SETTLE) ? 1 : 0, 1);
    end
  end

  task automatic run_cycle(input bit cap, input bit poke);
    int c0 = conv_n;
    @(negedge clk);
    start = 1; bias_cap = cap;
    @(negedge clk);
    start = 0; bias_cap = 0;
    while (conv_n < c0 + 2) @(negedge clk);
    chk("R7 cell1 held mid-cycle", int'(cell1_out), e_c1);
    chk("R7 cur held mid-cycle", int'(cur_out), e_cur);
    if (poke) begin
      start = 1; bias_cap = 1;
      @(negedge clk);
      start = 0; bias_cap = 0;
    end
    while (!cycle_done) @(negedge clk);
    e_c1 = v_c1 - v_short;
    e_c2 = v_c2 - v_short;
    e_t = v_thi - v_tlo;
    if (cap) begin
      bias_m = v_cur - v_short;
      e_cur = 0;
    end else e_cur = sat13(v_cur - v_short - bias_m);
    chk("R2 cell1", int'(cell1_out), e_c1);
    chk("R2 cell2", int'(cell2_out), e_c2);
    chk("R3 temp", int'(temp_out), e_t);
    chk(cap ? "R4 capture zero" : "R5 current", int'(cur_out), e_cur);
    chk("R1 conv count", conv_n - c0, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R1 order mux", rec_mux[(c0 + k) % 8], exp_mux(k));
      chk("R1 order ref", rec_ref[(c0 + k) % 8], (k == 6) ? 1 : 0);
    end
    @(negedge clk);
    chk("R8 done pulse width", int'(cycle_done), 0);
    repeat (10) @(negedge clk);
    if (poke) chk("R9 no extra conversions", conv_n - c0, 8);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    v_short = 0; v_c1 = 0; v_c2 = 0; v_cur = 0; v_thi = 0; v_tlo = 0;
    repeat (3) @(negedge clk);
    chk("R10 cell1 reset", int'(cell1_out), 0);
    chk("R10 cur reset", int'(cur_out), 0);
    chk("R10 temp reset", int'(temp_out), 0);
    chk("R10 start reset", int'(adc_start), 0);
    chk("R10 mux reset", int'(mux_sel), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R10 done idle", int'(cycle_done), 0);
    chk("R10 ref idle", int'(ref_hi), 0);
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 6; j++) begin
        v_short = off_of(i);
        v_c1 = sig_of(j);
        v_c2 = sig_of(5 - j);
        v_cur = sig_of((j + 2) % 6);
        v_thi = sig_of((j + 3) % 6);
        v_tlo = sig_of((j + 4) % 6);
        run_cycle(i == 2 && j == 0, j == 3);
      end
    end
    // R5 saturation high: bias -4095 then diff +4095
    v_short = 2047; v_cur = -2048;
    run_cycle(1, 0);
    v_short = -2048; v_cur = 2047;
    run_cycle(0, 0);
    chk("R5 saturate high", int'(cur_out), 4095);
    // R5 saturation low: bias +4095 then diff -4095
    run_cycle(1, 0);
    v_short = 2047; v_cur = -2048;
    run_cycle(0, 0);
    chk("R5 saturate low", int'(cur_out), -4096);
    // R9: busy start with bias_cap did not alter the bias
    v_short = 0; v_cur = 0;
    run_cycle(0, 1);
    chk("R9 bias unchanged", int'(cur_out), sat13(0 - 4095));
    finish_run();
  end
endmodule